// File: doc/BRIEF.md
# USB Wrapper Interrupt Aggregator

This block sits between a USB controller core and a CPU. It gathers the core's raw interrupt events into two groups, endpoint events and core events, and drives a single level interrupt line. Each group has a pending register that software clears by writing ones, and an enable mask that has separate write-one-to-set and write-one-to-clear addresses. The line goes high when an enabled event is pending. Once it has been high and has dropped, it stays low until software writes the end-of-interrupt address.

The same 32-bit register bus also carries a few wrapper controls. A revision word always reads nonzero. A control write pulses a reset to the attached core. A PHY control word holds an OTG-disable bit that software clears for host mode. Two read-only words report the live VBUS-drive level and the ID pin level. Reads return data one cycle after the address is presented, and writes take effect at the clock edge where they are presented.

Top module: `usb_irq_wrap`

## Requirements
- R1: While reset is held: irq, core_reset and bus_rdata are 0, both enable masks and both pending registers are 0, and otg_dis is 1.
- R2: Byte address 0x000 reads the revision word. Its default is 0x00000A01 and it is never zero. bus_rdata carries the value one cycle after the address is presented.
- R3: Endpoint events occupy 32-bit word positions 15:0 (transmit endpoints 0–15) and 31:17 (receive endpoints 1–15). Bit 16 never latches or enables and always reads 0. Endpoint pending is at 0x030, enable-set at 0x038, and enable-clear at 0x040.
- R4: Core events occupy bits 8:0, and bit 8 is the VBUS-drive change event. Bits 31:9 read 0. Core pending is at 0x034, enable-set at 0x03C, and enable-clear at 0x044.
- R5: A pending bit latches on its event pulse whether or not it is enabled. A pending bit that is not enabled never raises irq.
- R6: Writing ones to a pending address clears those bits and leaves the others unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays pending.
- R7: A write to an enable-set address sets only the bits written as one. A write to an enable-clear address clears only those bits. Both addresses of a group read the current mask.
- R8: irq rises two clock edges after the event pulse when the event is enabled and the line is armed. It stays high while any enabled bit is pending and falls one edge after the last such bit is cleared or disabled.
- R9: Once irq has been high, it does not rise again until a write of any value to address 0x024. The line is armed again from the edge of that write, and it is armed out of reset.
- R10: A write to 0x014 with bit 0 set gives core_reset high for exactly the cycle after the write edge. Address 0x014 reads 0.
- R11: Address 0x0E0 is a read/write PHY control word that resets to 0x00200000. Its bit 21 drives otg_dis.
- R12: Address 0x018 reads the live vbus_drv level in bit 0, and address 0x0E8 reads the live id_pin level in bit 8. All other bits of these words, and all unmapped addresses, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| ep_evt | input | 32 | Endpoint event pulses, in endpoint register layout |
| core_evt | input | 9 | Core event pulses |
| vbus_drv | input | 1 | Live VBUS-drive level |
| id_pin | input | 1 | Live ID pin level |
| irq | output | 1 | Level interrupt to the CPU |
| core_reset | output | 1 | One-cycle reset pulse to the attached core |
| otg_dis | output | 1 | OTG-disable control to the PHY |

## Verification
Effects have different delays, and each check is sampled at the cycle where its effect is due:

| Effect | When it is visible |
|---|---|
| Read data | One edge after the address is presented |
| Pending bits, enable bits, core_reset | At the edge of the event or write |
| irq | One edge after the pending or enable change, so two edges after an event pulse |

The bench drives inputs on the falling edge and samples on the next falling edge. It waits one extra falling edge before each irq check. For the cases where irq must stay low, it waits several cycles so that a late rise would be caught.

// File: rtl/usbw_pkg.sv
package usbw_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  // byte addresses of the wrapper words
  localparam logic [AW-1:0] A_REV       = 12'h000;
  localparam logic [AW-1:0] A_CTRL      = 12'h014;
  localparam logic [AW-1:0] A_STAT      = 12'h018;
  localparam logic [AW-1:0] A_EOI       = 12'h024;
  localparam logic [AW-1:0] A_EP_PEND   = 12'h030;
  localparam logic [AW-1:0] A_CORE_PEND = 12'h034;
  localparam logic [AW-1:0] A_EP_SET    = 12'h038;
  localparam logic [AW-1:0] A_CORE_SET  = 12'h03C;
  localparam logic [AW-1:0] A_EP_CLR    = 12'h040;
  localparam logic [AW-1:0] A_CORE_CLR  = 12'h044;
  localparam logic [AW-1:0] A_PHY       = 12'h0E0;
  localparam logic [AW-1:0] A_MODE      = 12'h0E8;
endpackage

// File: rtl/usbw_irq_group.sv
module usbw_irq_group #(
  parameter int W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] wdata,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         ack_we,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic         hit
);
  logic [W-1:0] pend_d, en_d;

  always_comb begin
    pend_d = ((pend & ~(ack_we ? wdata : '0)) | evt) & VALID;
    en_d   = en;
    if (set_we) en_d = en_d | wdata;
    if (clr_we) en_d = en_d & ~wdata;
    en_d = en_d & VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= pend_d;
      en   <= en_d;
    end
  end

  assign hit = |(pend & en);

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(evt & VALID)) == $past(evt & VALID))); // R6
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(en)); // R7
endmodule

// File: rtl/usbw_irq_line.sv
module usbw_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic eoi_we,
  output logic irq
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      irq <= hit & (armed_q | irq);
      if (eoi_we)   armed_q <= 1'b1;
      else if (irq) armed_q <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(hit)); // R8
  AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !irq && !eoi_we) |=> !irq); // R9
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap #(
  parameter int          TX_EP   = 16,
  parameter int          RX_EP   = 16,
  parameter int          RX_POS  = 16,
  parameter int          CORE_W  = 9,
  parameter logic [31:0] REV_VAL = 32'h0000_0A01,
  parameter int          OTG_BIT = 21,
  parameter int          ID_BIT  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [usbw_pkg::AW-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [31:0]           ep_evt,
  input  logic [8:0]            core_evt,
  input  logic                  vbus_drv,
  input  logic                  id_pin,
  output logic                  irq,
  output logic                  core_reset,
  output logic                  otg_dis
);
  import usbw_pkg::*;

  localparam logic [31:0] TX_MASK = 32'((64'd1 << TX_EP) - 64'd1);
  localparam logic [31:0] RX_MASK = 32'((((64'd1 << RX_EP) - 64'd1) & ~64'd1) << RX_POS);
  localparam logic [31:0] EP_VALID = TX_MASK | RX_MASK;
  localparam logic [CORE_W-1:0] CORE_VALID = '1;
  localparam logic [31:0] PHY_RST = 32'd1 << OTG_BIT;

  logic [31:0]       ep_pend, ep_en;
  logic [CORE_W-1:0] core_pend, core_en;
  logic              ep_hit, core_hit;
  logic [31:0]       phy_q, rd_d;
  logic              eoi_we;

  assign eoi_we = bus_we && (bus_addr == A_EOI);

  usbw_irq_group #(.W(32), .VALID(EP_VALID)) u_ep (
    .clk(clk), .rst(rst), .evt(ep_evt), .wdata(bus_wdata),
    .set_we(bus_we && bus_addr == A_EP_SET),
    .clr_we(bus_we && bus_addr == A_EP_CLR),
    .ack_we(bus_we && bus_addr == A_EP_PEND),
    .pend(ep_pend), .en(ep_en), .hit(ep_hit));

  usbw_irq_group #(.W(CORE_W), .VALID(CORE_VALID)) u_core (
    .clk(clk), .rst(rst), .evt(core_evt), .wdata(bus_wdata[CORE_W-1:0]),
    .set_we(bus_we && bus_addr == A_CORE_SET),
    .clr_we(bus_we && bus_addr == A_CORE_CLR),
    .ack_we(bus_we && bus_addr == A_CORE_PEND),
    .pend(core_pend), .en(core_en), .hit(core_hit));

  usbw_irq_line u_line (
    .clk(clk), .rst(rst), .hit(ep_hit | core_hit), .eoi_we(eoi_we), .irq(irq));

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      A_REV:                 rd_d = REV_VAL;
      A_STAT:                rd_d = {31'd0, vbus_drv};
      A_EP_PEND:             rd_d = ep_pend;
      A_CORE_PEND:           rd_d = 32'(core_pend);
      A_EP_SET, A_EP_CLR:    rd_d = ep_en;
      A_CORE_SET, A_CORE_CLR: rd_d = 32'(core_en);
      A_PHY:                 rd_d = phy_q;
      A_MODE:                rd_d = 32'(id_pin) << ID_BIT;
      default:               rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      phy_q      <= PHY_RST;
      core_reset <= 1'b0;
    end else begin
      bus_rdata  <= rd_d;
      core_reset <= bus_we && (bus_addr == A_CTRL) && bus_wdata[0];
      if (bus_we && bus_addr == A_PHY) phy_q <= bus_wdata;
    end
  end

  assign otg_dis = phy_q[OTG_BIT];

  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CTRL && bus_wdata[0]) |=> core_reset); // R10
  AST_REV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_REV) |=> (bus_rdata != 32'd0)); // R2
endmodule

// File: tb/usb_irq_wrap_tb.sv
`timescale 1ns/1ps
module usb_irq_wrap_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ep_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv = 1'b0;
  logic        id_pin = 1'b1;
  logic        irq, core_reset, otg_dis;
  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  usb_irq_wrap dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_evt(ep_evt),
    .core_evt(core_evt), .vbus_drv(vbus_drv), .id_pin(id_pin),
    .irq(irq), .core_reset(core_reset), .otg_dis(otg_dis));

  // fields: we | addr | wdata | expected read | requirement number
  localparam int NV = 17;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, 32'h0000_0A01, 4'd2},   // R2 revision
    {1'b0, 12'h0E0, 32'h0, 32'h0020_0000, 4'd11},  // R11 reset value
    {1'b1, 12'h0E0, 32'h0, 32'h0, 4'd11},
    {1'b0, 12'h0E0, 32'h0, 32'h0, 4'd11},
    {1'b0, 12'h0E8, 32'h0, 32'h0000_0100, 4'd12},  // R12 id level
    {1'b0, 12'h018, 32'h0, 32'h0, 4'd12},          // R12 vbus low
    {1'b1, 12'h038, 32'h000A_0005, 32'h0, 4'd7},
    {1'b0, 12'h038, 32'h0, 32'h000A_0005, 4'd7},   // R7 set
    {1'b1, 12'h040, 32'h0008_0001, 32'h0, 4'd7},
    {1'b0, 12'h040, 32'h0, 32'h0002_0004, 4'd7},   // R7 clear
    {1'b1, 12'h038, 32'h0001_0000, 32'h0, 4'd3},
    {1'b0, 12'h038, 32'h0, 32'h0002_0004, 4'd3},   // R3 bit 16 unused
    {1'b1, 12'h03C, 32'hFFFF_FFFF, 32'h0, 4'd4},
    {1'b0, 12'h03C, 32'h0, 32'h0000_01FF, 4'd4},   // R4 nine bits
    {1'b1, 12'h044, 32'h0000_01FF, 32'h0, 4'd7},
    {1'b0, 12'h044, 32'h0, 32'h0, 4'd7},
    {1'b0, 12'h014, 32'h0, 32'h0, 4'd10}           // R10 reads 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] ep, input logic [8:0] co);
    ep_evt = ep; core_evt = co;
    @(negedge clk);
    ep_evt = '0; core_evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 core_reset", {31'd0, core_reset}, 32'd0);
    chk("R1 otg_dis", {31'd0, otg_dis}, 32'd1);
    chk("R1 rdata", bus_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) wr(VEC[i][79:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][79:68], rv);
        chk($sformatf("R%0d table[%0d]", VEC[i][3:0], i), rv, VEC[i][35:4]);
      end
    end
    chk("R11 otg_dis cleared", {31'd0, otg_dis}, 32'd0);

    // R5: latch while disabled, no irq
    pulse('0, 9'h008);
    repeat (3) @(negedge clk);
    chk("R5 no irq when disabled", {31'd0, irq}, 32'd0);
    rd(12'h034, rv);
    chk("R5 pending latched", rv, 32'h8);

    // R8: enabling the pending bit raises irq one edge later
    wr(12'h03C, 32'h8);
    chk("R8 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq high", {31'd0, irq}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 irq stays", {31'd0, irq}, 32'd1);

    // R9: clear, refire blocked until EOI
    wr(12'h034, 32'h8);
    @(negedge clk);
    chk("R8 irq falls", {31'd0, irq}, 32'd0);
    pulse('0, 9'h008);
    repeat (4) @(negedge clk);
    chk("R9 no rearm", {31'd0, irq}, 32'd0);
    wr(12'h024, 32'h0);
    @(negedge clk);
    chk("R9 eoi rearms", {31'd0, irq}, 32'd1);
    wr(12'h034, 32'h8);
    @(negedge clk);
    chk("R9 cleared", {31'd0, irq}, 32'd0);

    // R8: event-to-irq latency when armed
    wr(12'h024, 32'h0);
    @(negedge clk);
    pulse('0, 9'h008);
    chk("R8 one edge after event", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 two edges after event", {31'd0, irq}, 32'd1);
    wr(12'h034, 32'h8);

    // R6: clear leaves others; event wins
    pulse('0, 9'h030);
    wr(12'h034, 32'h20);
    rd(12'h034, rv);
    chk("R6 clear one bit", rv, 32'h10);
    core_evt = 9'h010;
    wr(12'h034, 32'h10);
    core_evt = '0;
    rd(12'h034, rv);
    chk("R6 event wins", rv, 32'h10);
    wr(12'h034, 32'h1FF);

    // R3 and R4 layouts
    pulse(32'hFFFF_FFFF, 9'h1FF);
    rd(12'h030, rv);
    chk("R3 endpoint layout", rv, 32'hFFFE_FFFF);
    rd(12'h034, rv);
    chk("R4 core layout", rv, 32'h0000_01FF);
    wr(12'h034, 32'h0000_00FF);
    rd(12'h034, rv);
    chk("R4 vbus change bit 8", rv, 32'h0000_0100);

    // R10 reset pulse
    wr(12'h014, 32'h1);
    chk("R10 pulse high", {31'd0, core_reset}, 32'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", {31'd0, core_reset}, 32'd0);
    wr(12'h014, 32'h2);
    chk("R10 bit0 clear no pulse", {31'd0, core_reset}, 32'd0);

    // R12 live levels
    vbus_drv = 1'b1; id_pin = 1'b0;
    rd(12'h018, rv);
    chk("R12 vbus level", rv, 32'd1);
    rd(12'h0E8, rv);
    chk("R12 id level", rv, 32'd0);
    rd(12'h0FC, rv);
    chk("R12 unmapped", rv, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule